// File: doc/BRIEF.md
# Dual-Mode Serial Character Transmitter

This block turns a parallel character, written by a CPU-side port, into a bit stream on one serial output line. Two static pins choose the line format. In asynchronous format each character is wrapped in a low start bit and a high stop bit, and the line rests high between characters. In synchronous format there is no start or stop framing. Instead, one or two stored sync characters go out ahead of the data byte, and the line is filled with the first sync character whenever no frame is in flight.

The CPU loads the block through a write strobe and data bus. Right after reset, in synchronous format, the first accepted write fills the first sync slot. The second write fills the second slot, but only when two sync characters are selected. All later writes go to the data register. A frame begins when the start strobe and the byte-ready flag are high together. From then on, one bit advances per pulse of a bit-enable input. In synchronous format the data byte follows the sync characters only once the far end has raised its sync-detect handshake. Until then, the sync characters are sent again from the first one. Reset brings back the setup condition, so the mode pins can be changed.

Top module: `dual_serial_tx`

## Requirements
- R1: With comm_type 0 the block uses asynchronous format and sync_type has no effect. With comm_type 1 it uses synchronous format, with one sync character when sync_type is 0 and two when sync_type is 1.
- R2: An asynchronous frame is a 0 start bit, then the DATA_W data bits with the least significant bit first, then a 1 stop bit. Each bit stays on txd until the next bit_en pulse.
- R3: In asynchronous format txd is 1 whenever busy is low.
- R4: A synchronous frame is sync character 1, then sync character 2 when two are selected, then the data byte. Every character goes out least significant bit first, with no start or stop bit.
- R5: In synchronous format txd is 1 until the sync slots are loaded. Between frames it repeats sync character 1, least significant bit first, and a repetition starts with bit 0 right after a frame ends.
- R6: After reset, accepted writes fill sync slot 1, then sync slot 2 (two-sync format only), then the data register. In asynchronous format every accepted write goes to the data register.
- R7: A frame starts only if tx_start and byte_ready are both 1, busy is 0, and (in synchronous format) the sync slots are loaded. Otherwise tx_start has no effect.
- R8: In synchronous format, syndet is sampled at the last bit of the last sync character. If it is 0, the sync characters are sent again from character 1. The data byte follows only when it is 1.
- R9: busy is 1 from the clock edge that accepts tx_start until the edge that ends the final bit. A write while busy is 1 is ignored, so the held data character is sent again by a later start that has no new write.
- R10: An active-low rst_n clears the write order and all stored characters, and drives txd to 1 and busy to 0. The mode pins are read afresh after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| comm_type | input | 1 | 0 asynchronous format, 1 synchronous format |
| sync_type | input | 1 | In synchronous format: 0 one sync character, 1 two |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | DATA_W | Write data bus |
| byte_ready | input | 1 | Data-ready qualifier for tx_start |
| tx_start | input | 1 | Frame start request |
| bit_en | input | 1 | One pulse per bit period |
| syndet | input | 1 | Sync-detect handshake from the far end |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default DATA_W of 8 and MAX_SYNC of 2, and drives bit_en every fourth clock. This setup makes all three format settings reachable, along with the two-slot write order. A frame lasts long enough that writes can be placed mid-frame and syndet can be held low across two full sync repetitions. A scoreboard compares every framed bit with a queue that is filled from the requirements. Separate sampling covers the synchronous fill pattern after a frame and the idle-high line in asynchronous format.

// File: rtl/dual_serial_tx_pkg.sv
package dual_serial_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_SYNC,
      ST_DATA,
      ST_STOP
   } tx_state_e;

   typedef enum logic [1:0] {
      SRC_SYNC0,
      SRC_SYNC1,
      SRC_DATA
   } shift_src_e;

endpackage

// File: rtl/dual_serial_tx_loader.sv
module dual_serial_tx_loader
   import dual_serial_tx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MAX_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic              two_sync,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   output logic [DATA_W-1:0] sync_q [MAX_SYNC],
   output logic [DATA_W-1:0] data_q,
   output logic              cfg_ready
);

   localparam int PTR_W = $clog2(MAX_SYNC + 1);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] n_sync;
   logic             wr_acc;

   // number of sync slots the current mode expects
   always_comb begin
      n_sync = '0;
      if (sync_mode) begin
         n_sync = two_sync ? PTR_W'(2) : PTR_W'(1);
      end
   end

   assign wr_acc    = wr_en & ~busy;
   assign cfg_ready = (ptr_q >= n_sync);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (wr_acc && !cfg_ready) begin
         ptr_q <= ptr_q + PTR_W'(1);
      end
   end

   generate
      for (genvar i = 0; i < MAX_SYNC; i++) begin : g_slot
         logic [DATA_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (wr_acc && !cfg_ready && ptr_q == PTR_W'(i)) begin
               slot_q <= wr_data;
            end
         end
         assign sync_q[i] = slot_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (wr_acc && cfg_ready) begin
         data_q <= wr_data;
      end
   end

   // R9: held character never changes inside a frame
   p_hold_data_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(data_q));

   // R6: a write that fills a sync slot leaves the data register alone
   p_write_order_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && !cfg_ready) |=> $stable(data_q));

endmodule

// File: rtl/dual_serial_tx_shifter.sv
module dual_serial_tx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] load_val,
   output logic              lsb
);

   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= load_val;
      end else if (shift) begin
         sh_q <= {1'b0, sh_q[DATA_W-1:1]};
      end
   end

   assign lsb = sh_q[0];

endmodule

// File: rtl/dual_serial_tx_seq.sv
module dual_serial_tx_seq
   import dual_serial_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_mode,
   input  logic       two_sync,
   input  logic       cfg_ready,
   input  logic       tx_start,
   input  logic       byte_ready,
   input  logic       bit_en,
   input  logic       syndet,
   output tx_state_e  state,
   output logic       fill_armed,
   output logic       sh_load,
   output shift_src_e sh_src,
   output logic       sh_shift,
   output logic       busy
);

   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   tx_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             sidx_q, sidx_d;
   logic             armed_q, armed_d;
   logic             start_ok;
   logic             last_bit;

   assign start_ok = tx_start & byte_ready & cfg_ready & (state_q == ST_IDLE);
   assign last_bit = (cnt_q == CNT_W'(DATA_W - 1));

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      sidx_d   = sidx_q;
      armed_d  = armed_q;
      sh_load  = 1'b0;
      sh_src   = SRC_SYNC0;
      sh_shift = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_ok) begin
               cnt_d = '0;
               if (sync_mode) begin
                  state_d = ST_SYNC;
                  sidx_d  = 1'b0;
                  sh_load = 1'b1;
                  armed_d = 1'b1;
               end else begin
                  state_d = ST_START;
               end
            end else if (sync_mode && cfg_ready && !armed_q) begin
               sh_load = 1'b1;
               cnt_d   = '0;
               armed_d = 1'b1;
            end else if (sync_mode && armed_q && bit_en) begin
               if (last_bit) begin
                  sh_load = 1'b1;
                  cnt_d   = '0;
               end else begin
                  sh_shift = 1'b1;
                  cnt_d    = cnt_q + CNT_W'(1);
               end
            end
         end
         ST_START: begin
            if (bit_en) begin
               state_d = ST_DATA;
               sh_load = 1'b1;
               sh_src  = SRC_DATA;
               cnt_d   = '0;
            end
         end
         ST_SYNC: begin
            if (bit_en) begin
               if (!last_bit) begin
                  sh_shift = 1'b1;
                  cnt_d    = cnt_q + CNT_W'(1);
               end else if (two_sync && !sidx_q) begin
                  sidx_d  = 1'b1;
                  sh_load = 1'b1;
                  sh_src  = SRC_SYNC1;
                  cnt_d   = '0;
               end else if (syndet) begin
                  state_d = ST_DATA;
                  sh_load = 1'b1;
                  sh_src  = SRC_DATA;
                  cnt_d   = '0;
               end else begin
                  sidx_d  = 1'b0;
                  sh_load = 1'b1;
                  cnt_d   = '0;
               end
            end
         end
         ST_DATA: begin
            if (bit_en) begin
               if (!last_bit) begin
                  sh_shift = 1'b1;
                  cnt_d    = cnt_q + CNT_W'(1);
               end else if (sync_mode) begin
                  state_d = ST_IDLE;
                  sh_load = 1'b1;
                  cnt_d   = '0;
               end else begin
                  state_d = ST_STOP;
               end
            end
         end
         ST_STOP: begin
            if (bit_en) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sidx_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         sidx_q  <= sidx_d;
         armed_q <= armed_d;
      end
   end

   assign state      = state_q;
   assign fill_armed = armed_q;
   assign busy       = (state_q != ST_IDLE);

   // R7: a frame opens only on a qualified start request
   p_start_qualified_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tx_start && byte_ready && cfg_ready));

   // R8: data after sync characters only with the handshake up
   p_syndet_gate_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && $past(state_q) == ST_SYNC) |-> $past(syndet));

   // R1: asynchronous format never visits the sync state
   p_async_no_sync_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_mode && $past(!sync_mode)) |-> (state_q != ST_SYNC));

endmodule

// File: rtl/dual_serial_tx.sv
module dual_serial_tx
   import dual_serial_tx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MAX_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              comm_type,
   input  logic              sync_type,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              byte_ready,
   input  logic              tx_start,
   input  logic              bit_en,
   input  logic              syndet,
   output logic              txd,
   output logic              busy
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dual_serial_tx: DATA_W must be at least 2");
      end
      if (MAX_SYNC < 2) begin : g_bad_sync
         $error("dual_serial_tx: MAX_SYNC must be at least 2");
      end
   endgenerate

   logic              sync_mode;
   logic              two_sync;
   logic [DATA_W-1:0] sync_q [MAX_SYNC];
   logic [DATA_W-1:0] data_q;
   logic              cfg_ready;
   tx_state_e         state;
   logic              fill_armed;
   logic              sh_load;
   shift_src_e        sh_src;
   logic              sh_shift;
   logic [DATA_W-1:0] load_val;
   logic              sh_lsb;

   assign sync_mode = comm_type;
   assign two_sync  = comm_type & sync_type;

   dual_serial_tx_loader #(
      .DATA_W   (DATA_W),
      .MAX_SYNC (MAX_SYNC)
   ) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_mode (sync_mode),
      .two_sync  (two_sync),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .busy      (busy),
      .sync_q    (sync_q),
      .data_q    (data_q),
      .cfg_ready (cfg_ready)
   );

   dual_serial_tx_seq #(
      .DATA_W (DATA_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_mode  (sync_mode),
      .two_sync   (two_sync),
      .cfg_ready  (cfg_ready),
      .tx_start   (tx_start),
      .byte_ready (byte_ready),
      .bit_en     (bit_en),
      .syndet     (syndet),
      .state      (state),
      .fill_armed (fill_armed),
      .sh_load    (sh_load),
      .sh_src     (sh_src),
      .sh_shift   (sh_shift),
      .busy       (busy)
   );

   always_comb begin
      unique case (sh_src)
         SRC_SYNC1: load_val = sync_q[1];
         SRC_DATA:  load_val = data_q;
         default:   load_val = sync_q[0];
      endcase
   end

   dual_serial_tx_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .shift    (sh_shift),
      .load_val (load_val),
      .lsb      (sh_lsb)
   );

   always_comb begin
      unique case (state)
         ST_START: txd = 1'b0;
         ST_STOP:  txd = 1'b1;
         ST_SYNC,
         ST_DATA:  txd = sh_lsb;
         default:  txd = (sync_mode && fill_armed) ? sh_lsb : 1'b1;
      endcase
   end

   // R3: asynchronous line rests high
   p_async_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !comm_type) |-> txd);

   // R2: an asynchronous frame opens with a low start bit
   p_start_bit_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !comm_type) |-> !txd);

   // R10: out of reset the line is high and idle
   p_reset_idle_r10 : assert property (@(posedge clk)
      $rose(rst_n) |-> (txd && !busy));

endmodule

// File: tb/dual_serial_tx_tb_top.sv
`timescale 1ns/1ps
module dual_serial_tx_tb_top;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          comm_type = 1'b0;
   logic          sync_type = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          byte_ready = 1'b0;
   logic          tx_start = 1'b0;
   logic          bit_en = 1'b0;
   logic          syndet = 1'b0;
   logic          txd;
   logic          busy;

   int n_tests = 0;
   int n_fail  = 0;
   int n_pop   = 0;
   int div     = 0;

   bit exp_q[$];
   int tag_q[$];

   always #4 clk = ~clk;

   dual_serial_tx #(.DATA_W(DW), .MAX_SYNC(2)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .comm_type  (comm_type),
      .sync_type  (sync_type),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .byte_ready (byte_ready),
      .tx_start   (tx_start),
      .bit_en     (bit_en),
      .syndet     (syndet),
      .txd        (txd),
      .busy       (busy)
   );

   // bit-enable every fourth clock, changed away from the active edge
   always @(negedge clk) begin
      div    <= (div == 3) ? 0 : div + 1;
      bit_en <= (div == 3);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every framed bit consumed by a bit_en edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && busy && bit_en) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2/R4 unexpected bit", int'(txd), 0);
            end else begin
               automatic bit e = exp_q.pop_front();
               automatic int t = tag_q.pop_front();
               check(txd == e, $sformatf("R%0d frame bit %0d", t, n_pop), int'(txd), int'(e));
            end
            n_pop++;
         end
      end
   end

   task automatic push_bit(input bit b, input int t);
      exp_q.push_back(b);
      tag_q.push_back(t);
   endtask

   task automatic push_byte(input logic [DW-1:0] b, input int t);
      for (int i = 0; i < DW; i++) push_bit(b[i], t);
   endtask

   task automatic push_async(input logic [DW-1:0] b);
      push_bit(1'b0, 2);
      push_byte(b, 2);
      push_bit(1'b1, 2);
   endtask

   task automatic wr(input logic [DW-1:0] b);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic pulse_start(input bit expect_busy, input string req);
      @(negedge clk);
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      #1;
      check(busy == expect_busy, req, int'(busy), int'(expect_busy));
   endtask

   task automatic wait_done();
      while (busy || exp_q.size() != 0) @(negedge clk);
      #1;
   endtask

   task automatic do_reset(input bit ct, input bit st);
      @(negedge clk);
      rst_n     = 1'b0;
      comm_type = ct;
      sync_type = st;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(txd == 1'b1 && busy == 1'b0, "R10 reset state", {txd, busy}, 2'b10);
   endtask

   task automatic check_fill(input logic [DW-1:0] s);
      logic [DW-1:0] got;
      int k;
      k = 0;
      while (k < DW) begin
         @(negedge clk);
         #1;
         if (bit_en && !busy) begin
            got[k] = txd;
            k++;
         end
      end
      check(got == s, "R5 sync idle fill", got, s);
   endtask

   task automatic check_async_idle(input int cycles);
      logic all_hi;
      all_hi = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         #1;
         if (!busy && !txd) all_hi = 1'b0;
      end
      check(all_hi, "R3 async idle high", all_hi, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1..R10 actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: asynchronous with sync_type high, which must have no effect
      do_reset(1'b0, 1'b1);
      check_async_idle(6);
      wr(8'h55);            // R6: first write lands in data
      byte_ready = 1'b1;
      push_async(8'h55);
      pulse_start(1'b1, "R9 busy after start");
      wait_done();
      check_async_idle(12);

      // R7: start without byte_ready is ignored
      byte_ready = 1'b0;
      pulse_start(1'b0, "R7 start without byte_ready");
      check_async_idle(8);
      byte_ready = 1'b1;

      wr(8'hA3);
      push_async(8'hA3);
      pulse_start(1'b1, "R9 busy after start");
      wait_done();
      wr(8'h80);
      push_async(8'h80);
      pulse_start(1'b1, "R9 busy after start");
      wait_done();

      // R9: write while busy ignored, held character resent
      wr(8'h3C);
      push_async(8'h3C);
      pulse_start(1'b1, "R9 busy after start");
      wr(8'hFF);
      wait_done();
      push_async(8'h3C);
      pulse_start(1'b1, "R9 busy after start");
      wait_done();

      // R10/R1: synchronous, single sync character
      do_reset(1'b1, 1'b0);
      pulse_start(1'b0, "R7 start before sync loaded");
      check(txd == 1'b1, "R5 line high before setup", txd, 1);
      wr(8'hA5);
      wr(8'h5A);
      syndet = 1'b1;
      push_byte(8'hA5, 4);
      push_byte(8'h5A, 4);
      pulse_start(1'b1, "R9 busy after sync start");
      wait_done();
      check_fill(8'hA5);

      // R8: handshake low repeats the sync character
      syndet = 1'b0;
      wr(8'h0F);
      push_byte(8'hA5, 8);
      push_byte(8'hA5, 8);
      push_byte(8'hA5, 8);
      push_byte(8'h0F, 8);
      begin
         automatic int base = n_pop;
         pulse_start(1'b1, "R9 busy after sync start");
         wait (n_pop >= base + 20);
         #1;
         check(busy == 1'b1, "R8 frame held by syndet", busy, 1);
         syndet = 1'b1;
      end
      wait_done();

      // R1/R4/R6: two sync characters
      do_reset(1'b1, 1'b1);
      wr(8'h16);
      wr(8'h68);
      wr(8'hC3);
      push_byte(8'h16, 4);
      push_byte(8'h68, 4);
      push_byte(8'hC3, 4);
      pulse_start(1'b1, "R9 busy after sync start");
      wait_done();
      check_fill(8'h16);

      // R10: reset back to asynchronous, first write is data again
      do_reset(1'b0, 1'b0);
      wr(8'h99);
      push_async(8'h99);
      pulse_start(1'b1, "R9 busy after start");
      wait_done();
      check_async_idle(8);

      check(exp_q.size() == 0, "R2/R4 scoreboard drained", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule